// File: doc/BRIEF.md
# PHY Management Register Access Controller

This block lets software reach the management registers of external Ethernet PHYs without bit-banging the serial management bus. Software loads a data/port register, an optional MMD address register and, for writes, a 64-bit one-hot port mask. It then writes an access-control word whose lowest bit starts the job. The controller checks the request against the legal ranges. It runs one or two frames on an MDIO-style two-wire interface: a page-select frame before a paged clause-22 access, or an address frame before an MMD access. Execute reads back as 1 until the job is complete. A read that no PHY answers raises a failure flag.

Transactions are driven by a command sequencer with the states IDLE, DECODE, PAGE_GO, PAGE_WAIT, ADDR_GO, ADDR_WAIT, XFER_GO and XFER_WAIT. A start moves IDLE to DECODE. From DECODE the sequencer goes to IDLE when the request is out of range (failure set), to ADDR_GO for MMD, to XFER_GO for a raw-page access, and otherwise to PAGE_GO. Each *_GO state lasts one cycle and leads to its *_WAIT state. PAGE_WAIT and ADDR_WAIT move to XFER_GO when their frame completes, and XFER_WAIT returns to IDLE. The serial shifter has the states SH_IDLE, SH_LOW and SH_HIGH. A launch moves SH_IDLE to SH_LOW. SH_LOW always moves to SH_HIGH after one half period. SH_HIGH returns to SH_LOW for the next bit, or to SH_IDLE after the last bit.

Top module: `phy_mgmt_ctrl`

## Requirements
- R1: After reset every host register (address 0 access word, 1 data/port, 2 MMD address, 3 mask low half, 4 mask high half) reads 0, and MDC and the MDIO output enable are low while the controller is idle.
- R2: The access word keeps execute at bit 0, failure at bit 1, MMD at bit 2, write at bit 3, register number at bits 9:5, page at bits 22:10 and a raw tag at bits 27:23. Writing it with bit 0 set while idle starts a job. Bit 0 reads 1 until the job ends and then clears by itself, while bits 27:2 read back as written.
- R3: A paged clause-22 read takes the port from data bits 31:16. It first sends a write frame (start 01, opcode 01) to register 31 with the page as data, then a read frame (start 01, opcode 10) to the target register. The PHY address is the port number modulo 32, and the returned 16 bits appear in data bits 15:0.
- R4: A clause-22 write takes the target port from the lowest set bit of the 64-bit mask and the data from data bits 31:16. It sends the same page-select frame followed by a write frame (opcode 01) carrying that data.
- R5: When the page is 0x1FFF and the raw tag is 0x1F, no page-select frame is sent and only the target frame is issued.
- R6: A read to port above 63, a clause-22 page above 4095 that is not the raw case, a write with an empty mask, or an MMD device above 31 sends no frame, sets failure and clears execute.
- R7: An MMD access ignores the page. It sends an address frame (start 00, opcode 00, device in the register field, register number from MMD bits 15:0 as data), then a frame with opcode 11 for a read or 01 for a write. The device comes from MMD bits 31:16.
- R8: If the PHY does not pull the second turnaround bit low during a read frame, failure is set and data bits 15:0 keep their old value. Failure clears when the next job starts.
- R9: Every frame starts with 32 ones, drives turnaround 10 on driven frames, and releases the line for the last 18 bits of read frames. Each MDC period is 2*DIV_HALF clocks.
- R10: While a job runs, host writes to any register are ignored.
- R11: Host writes never change data bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the controller |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data seen on the line |

## Verification
A wrong sequencer state shows up at the serial pins within one frame of the start: a missing or extra page-select or address frame, or a wrong opcode in the header. Execute also stays set, or clears too early, on the next host read. A shifter that miscounts bits corrupts the captured 64-bit frame and moves the point where the line is released. A faulty failure or read-data path is visible in the first access-word or data-register read after the job ends. Register writes that slip through while a job is busy appear as a changed readback or as an unexpected frame.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
    localparam int FRAME_W   = 64;
    localparam int PRE_W     = 32;
    localparam int PORT_CNT  = 64;

    localparam logic [2:0] RA_ACCESS  = 3'd0;
    localparam logic [2:0] RA_DATA    = 3'd1;
    localparam logic [2:0] RA_MMD     = 3'd2;
    localparam logic [2:0] RA_MASK_LO = 3'd3;
    localparam logic [2:0] RA_MASK_HI = 3'd4;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH
    } sh_state_t;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_DECODE,
        SQ_PAGE_GO,
        SQ_PAGE_WAIT,
        SQ_ADDR_GO,
        SQ_ADDR_WAIT,
        SQ_XFER_GO,
        SQ_XFER_WAIT
    } sq_state_t;

    // preamble, start, opcode, phy, register/device, turnaround, data
    function automatic logic [FRAME_W-1:0] build_frame(
        input logic [1:0]  st,
        input logic [1:0]  op,
        input logic [4:0]  phy,
        input logic [4:0]  regn,
        input logic [15:0] data
    );
        return {{PRE_W{1'b1}}, st, op, phy, regn, 2'b10, data};
    endfunction

    // {found, port index modulo 32} of the lowest set mask bit
    function automatic logic [5:0] lowest_port(input logic [PORT_CNT-1:0] m);
        logic [5:0] r;
        r = '0;
        for (int i = PORT_CNT - 1; i >= 0; i--) begin
            if (m[i]) r = {1'b1, 5'(i)};
        end
        return r;
    endfunction
endpackage

// File: rtl/phy_mgmt_mdio.sv
module phy_mgmt_mdio
    import phy_mgmt_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               rd_i,
    input  logic               mdio_i,
    output logic               mdc_o,
    output logic               mdio_o,
    output logic               mdio_oe_o,
    output logic               done_o,
    output logic [15:0]        rdata_o,
    output logic               ta_bad_o
);
    localparam int CNT_W = (DIV_HALF < 2) ? 1 : $clog2(DIV_HALF);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);
    localparam int IDX_W = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] BIT_LAST   = IDX_W'(FRAME_W - 1);
    localparam logic [IDX_W-1:0] BIT_REL    = IDX_W'(FRAME_W - 18);
    localparam logic [IDX_W-1:0] BIT_TA2    = IDX_W'(FRAME_W - 17);
    localparam logic [IDX_W-1:0] BIT_DATA0  = IDX_W'(FRAME_W - 16);

    sh_state_t           state, state_nx;
    logic [CNT_W-1:0]    div_cnt;
    logic [IDX_W-1:0]    bit_idx;
    logic [FRAME_W-1:0]  shreg;
    logic                rd_q;
    logic                half_end;

    assign half_end = (div_cnt == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SH_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SH_IDLE: if (go_i)     state_nx = SH_LOW;
            SH_LOW:  if (half_end) state_nx = SH_HIGH;
            SH_HIGH: if (half_end) state_nx = (bit_idx == BIT_LAST) ? SH_IDLE : SH_LOW;
            default: state_nx = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt  <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            rd_q     <= 1'b0;
            rdata_o  <= '0;
            ta_bad_o <= 1'b0;
        end else begin
            unique case (state)
                SH_IDLE: begin
                    if (go_i) begin
                        shreg    <= frame_i;
                        rd_q     <= rd_i;
                        bit_idx  <= '0;
                        div_cnt  <= '0;
                        ta_bad_o <= 1'b0;
                        rdata_o  <= '0;
                    end
                end
                SH_LOW: begin
                    if (half_end) begin
                        div_cnt <= '0;
                        if (bit_idx == BIT_TA2)   ta_bad_o <= mdio_i;
                        if (bit_idx >= BIT_DATA0) rdata_o  <= {rdata_o[14:0], mdio_i};
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                SH_HIGH: begin
                    if (half_end) begin
                        div_cnt <= '0;
                        if (bit_idx != BIT_LAST) begin
                            bit_idx <= bit_idx + 1'b1;
                            shreg   <= {shreg[FRAME_W-2:0], 1'b0};
                        end
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mdc_o     = (state == SH_HIGH);
        mdio_o    = shreg[FRAME_W-1];
        mdio_oe_o = (state != SH_IDLE) && (!rd_q || (bit_idx < BIT_REL));
        done_o    = (state == SH_HIGH) && half_end && (bit_idx == BIT_LAST);
    end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic [2:0]          host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    input  logic                busy_i,
    input  logic                fail_set_i,
    input  logic                rd_upd_i,
    input  logic [15:0]         rd_val_i,
    output logic                start_o,
    output logic                fail_o,
    output logic [27:2]         acc_o,
    output logic [15:0]         data_hi_o,
    output logic [DATA_W-1:0]   mmd_o,
    output logic [PORT_CNT-1:0] mask_o
);
    localparam int HALF = DATA_W / 2;

    logic [15:0] data_lo;
    logic        wr_ok;

    assign wr_ok   = host_wr && !busy_i;
    assign start_o = wr_ok && (host_addr == RA_ACCESS) && host_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o     <= '0;
            data_hi_o <= '0;
            data_lo   <= '0;
            mmd_o     <= '0;
            mask_o    <= '0;
            fail_o    <= 1'b0;
        end else begin
            if (wr_ok) begin
                unique case (host_addr)
                    RA_ACCESS:  acc_o     <= host_wdata[27:2];
                    RA_DATA:    data_hi_o <= host_wdata[DATA_W-1:HALF];
                    RA_MMD:     mmd_o     <= host_wdata;
                    RA_MASK_LO: mask_o[DATA_W-1:0]          <= host_wdata;
                    RA_MASK_HI: mask_o[PORT_CNT-1:DATA_W]   <= host_wdata;
                    default: ;
                endcase
            end
            if (rd_upd_i) data_lo <= rd_val_i;
            if (start_o)         fail_o <= 1'b0;
            else if (fail_set_i) fail_o <= 1'b1;
        end
    end

    always_comb begin
        unique case (host_addr)
            RA_ACCESS:  host_rdata = {4'b0, acc_o, fail_o, busy_i};
            RA_DATA:    host_rdata = {data_hi_o, data_lo};
            RA_MMD:     host_rdata = mmd_o;
            RA_MASK_LO: host_rdata = mask_o[DATA_W-1:0];
            RA_MASK_HI: host_rdata = mask_o[PORT_CNT-1:DATA_W];
            default:    host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/phy_mgmt_seq.sv
module phy_mgmt_seq
    import phy_mgmt_pkg::*;
#(
    parameter int PORT_LIMIT = 63,
    parameter int PAGE_LIMIT = 4095,
    parameter int DEV_LIMIT  = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [27:2]         acc_i,
    input  logic [15:0]         data_hi_i,
    input  logic [31:0]         mmd_i,
    input  logic [PORT_CNT-1:0] mask_i,
    input  logic                sh_done_i,
    input  logic                sh_ta_bad_i,
    input  logic [15:0]         sh_rdata_i,
    output logic                busy_o,
    output logic                sh_go_o,
    output logic [FRAME_W-1:0]  sh_frame_o,
    output logic                sh_rd_o,
    output logic                fail_set_o,
    output logic                rd_upd_o,
    output logic [15:0]         rd_val_o
);
    localparam logic [4:0]  RAW_TAG  = 5'h1F;
    localparam logic [12:0] RAW_PAGE = 13'h1FFF;
    localparam logic [4:0]  PAGE_REG = 5'd31;

    sq_state_t   state, state_nx;
    logic        is_wr, is_mmd, raw, port_ok, page_ok, dev_ok, valid;
    logic [12:0] page;
    logic [4:0]  regn, dev, phy;
    logic [5:0]  sel;

    always_comb begin
        is_wr   = acc_i[3];
        is_mmd  = acc_i[2];
        regn    = acc_i[9:5];
        page    = acc_i[22:10];
        raw     = (acc_i[27:23] == RAW_TAG) && (page == RAW_PAGE);
        sel     = lowest_port(mask_i);
        phy     = is_wr ? sel[4:0] : data_hi_i[4:0];
        port_ok = is_wr ? sel[5] : (data_hi_i <= 16'(PORT_LIMIT));
        page_ok = raw || (page <= 13'(PAGE_LIMIT));
        dev_ok  = (mmd_i[31:16] <= 16'(DEV_LIMIT));
        dev     = mmd_i[20:16];
        valid   = port_ok && (is_mmd ? dev_ok : page_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE:      if (start_i) state_nx = SQ_DECODE;
            SQ_DECODE: begin
                if (!valid)      state_nx = SQ_IDLE;
                else if (is_mmd) state_nx = SQ_ADDR_GO;
                else if (raw)    state_nx = SQ_XFER_GO;
                else             state_nx = SQ_PAGE_GO;
            end
            SQ_PAGE_GO:   state_nx = SQ_PAGE_WAIT;
            SQ_PAGE_WAIT: if (sh_done_i) state_nx = SQ_XFER_GO;
            SQ_ADDR_GO:   state_nx = SQ_ADDR_WAIT;
            SQ_ADDR_WAIT: if (sh_done_i) state_nx = SQ_XFER_GO;
            SQ_XFER_GO:   state_nx = SQ_XFER_WAIT;
            SQ_XFER_WAIT: if (sh_done_i) state_nx = SQ_IDLE;
            default:      state_nx = SQ_IDLE;
        endcase
    end

    always_comb begin
        busy_o     = (state != SQ_IDLE);
        sh_go_o    = 1'b0;
        sh_rd_o    = 1'b0;
        sh_frame_o = '0;
        fail_set_o = 1'b0;
        rd_upd_o   = 1'b0;
        rd_val_o   = sh_rdata_i;
        unique case (state)
            SQ_DECODE: fail_set_o = !valid;
            SQ_PAGE_GO: begin
                sh_go_o    = 1'b1;
                sh_frame_o = build_frame(2'b01, 2'b01, phy, PAGE_REG, {3'b0, page});
            end
            SQ_ADDR_GO: begin
                sh_go_o    = 1'b1;
                sh_frame_o = build_frame(2'b00, 2'b00, phy, dev, mmd_i[15:0]);
            end
            SQ_XFER_GO: begin
                sh_go_o = 1'b1;
                sh_rd_o = !is_wr;
                if (is_mmd)
                    sh_frame_o = build_frame(2'b00, is_wr ? 2'b01 : 2'b11, phy, dev,
                                             is_wr ? data_hi_i : 16'h0);
                else
                    sh_frame_o = build_frame(2'b01, is_wr ? 2'b01 : 2'b10, phy, regn,
                                             is_wr ? data_hi_i : 16'h0);
            end
            SQ_XFER_WAIT: begin
                if (sh_done_i && !is_wr) begin
                    fail_set_o = sh_ta_bad_i;
                    rd_upd_o   = !sh_ta_bad_i;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
    import phy_mgmt_pkg::*;
#(
    parameter int DIV_HALF   = 2,
    parameter int PORT_LIMIT = 63,
    parameter int PAGE_LIMIT = 4095,
    parameter int DEV_LIMIT  = 31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [2:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic                busy, start, fail_q, fail_set, rd_upd;
    logic [15:0]         rd_val, data_hi, sh_rdata;
    logic [27:2]         acc;
    logic [31:0]         mmd;
    logic [PORT_CNT-1:0] mask;
    logic                sh_go, sh_rd, sh_done, sh_ta_bad;
    logic [FRAME_W-1:0]  sh_frame;

    phy_mgmt_regs #(.DATA_W(32)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy_i     (busy),
        .fail_set_i (fail_set),
        .rd_upd_i   (rd_upd),
        .rd_val_i   (rd_val),
        .start_o    (start),
        .fail_o     (fail_q),
        .acc_o      (acc),
        .data_hi_o  (data_hi),
        .mmd_o      (mmd),
        .mask_o     (mask)
    );

    phy_mgmt_seq #(
        .PORT_LIMIT (PORT_LIMIT),
        .PAGE_LIMIT (PAGE_LIMIT),
        .DEV_LIMIT  (DEV_LIMIT)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .acc_i       (acc),
        .data_hi_i   (data_hi),
        .mmd_i       (mmd),
        .mask_i      (mask),
        .sh_done_i   (sh_done),
        .sh_ta_bad_i (sh_ta_bad),
        .sh_rdata_i  (sh_rdata),
        .busy_o      (busy),
        .sh_go_o     (sh_go),
        .sh_frame_o  (sh_frame),
        .sh_rd_o     (sh_rd),
        .fail_set_o  (fail_set),
        .rd_upd_o    (rd_upd),
        .rd_val_o    (rd_val)
    );

    phy_mgmt_mdio #(.DIV_HALF(DIV_HALF)) u_mdio (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (sh_go),
        .frame_i   (sh_frame),
        .rd_i      (sh_rd),
        .mdio_i    (mdio_i),
        .mdc_o     (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe),
        .done_o    (sh_done),
        .rdata_o   (sh_rdata),
        .ta_bad_o  (sh_ta_bad)
    );
endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        fail_q,
    input logic        mdc,
    input logic        mdio_oe,
    input logic        host_wr,
    input logic [2:0]  host_addr,
    input logic [15:0] data_hi
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R8
    fail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !fail_q);

    // R8
    fail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_q) |-> $past(busy));

    // R10
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr && host_addr == 3'd1) |=> $stable(data_hi));
endmodule

bind phy_mgmt_ctrl phy_mgmt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .fail_q    (fail_q),
    .mdc       (mdc),
    .mdio_oe   (mdio_oe),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .data_hi   (data_hi)
);

// File: tb/sim_phy_mgmt_ctrl.sv
module sim_phy_mgmt_ctrl;
    localparam int DIVH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [31:0] host_wdata = 32'd0;
    logic [31:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #5 clk = ~clk;

    phy_mgmt_ctrl #(.DIV_HALF(DIVH)) u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int n_chk = 0;
    int n_fail = 0;

    // PHY model
    logic        phy_present = 1'b1;
    logic [15:0] rd_resp = 16'h0;
    logic [63:0] flog [16];
    logic        oe46 [16];
    int          fcnt = 0;
    int          bitn = 0;
    int          since_rise = 0;
    int          rise_gap = 0;
    logic        active = 1'b0;
    logic        is_rd = 1'b0;
    logic        cur_oe46 = 1'b0;
    logic [63:0] sh = '0;
    logic        p_mdc = 1'b0;
    logic        p_oe = 1'b0;

    always @(negedge clk) begin
        since_rise++;
        if (mdio_oe && !p_oe && !active) begin
            active = 1'b1; bitn = 0; sh = '0;
        end
        if (active && mdc && !p_mdc) begin
            rise_gap = since_rise; since_rise = 0;
            sh = {sh[62:0], mdio_oe ? mdio_o : mdio_i};
            if (bitn == 46) cur_oe46 = mdio_oe;
            bitn++;
            if (bitn == 64) begin
                flog[fcnt % 16] = sh;
                oe46[fcnt % 16] = cur_oe46;
                fcnt++;
                active = 1'b0;
            end
        end
        if (!mdc && p_mdc) begin
            if (active && bitn == 46) begin
                is_rd = sh[11];
                mdio_i = 1'b1;
            end else if (active && bitn == 47)
                mdio_i = (is_rd && phy_present) ? 1'b0 : 1'b1;
            else if (active && bitn >= 48)
                mdio_i = (is_rd && phy_present) ? rd_resp[63 - bitn] : 1'b1;
            else
                mdio_i = 1'b1;
        end
        p_mdc = mdc;
        p_oe  = mdio_oe;
    end

    function automatic logic [63:0] ef(input logic [1:0] st, input logic [1:0] op,
                                       input logic [4:0] phy, input logic [4:0] rg,
                                       input logic [15:0] d);
        return {32'hFFFF_FFFF, st, op, phy, rg, 2'b10, d};
    endfunction

    function automatic logic [31:0] acc(input bit wr, input bit mmd, input int page,
                                        input int rg, input bit raw);
        return (32'(page) << 10) | (32'(rg) << 5) | (raw ? (32'h1F << 23) : 32'h0)
             | (wr ? 32'h8 : 32'h0) | (mmd ? 32'h4 : 32'h0) | 32'h1;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 4000; i++) begin
            hr(3'd0, v);
            if (!v[0]) return;
        end
        chk("R2 execute never cleared", 64'(v[0]), 64'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 5; a++) begin
            hr(3'(a), v);
            chk("R1 reset register", 64'(v), 64'd0);
        end
        chk("R1 mdc idle", 64'(mdc), 64'd0);
        chk("R1 oe idle", 64'(mdio_oe), 64'd0);
    endtask

    task automatic t_paged_read();
        logic [31:0] v, w;
        int base;
        base = fcnt; rd_resp = 16'hBEEF;
        w = acc(0, 0, 3, 9, 0);
        hw(3'd1, 32'd40 << 16);
        hw(3'd0, w);
        hr(3'd0, v);
        chk("R2 execute set while busy", 64'(v[0]), 64'd1);
        wait_idle();
        chk("R3 frame count", 64'(fcnt - base), 64'd2);
        chk("R3 page select frame", flog[base % 16], ef(2'b01, 2'b01, 5'd8, 5'd31, 16'd3));
        chk("R3 read frame", flog[(base + 1) % 16], ef(2'b01, 2'b10, 5'd8, 5'd9, 16'hBEEF));
        hr(3'd1, v);
        chk("R3 read data", 64'(v), 64'h0028_BEEF);
        hr(3'd0, v);
        chk("R2 access readback", 64'(v), 64'(w & ~32'h1));
        chk("R9 mdc period", 64'(rise_gap), 64'(2 * DIVH));
        chk("R9 read releases line", 64'(oe46[(base + 1) % 16]), 64'd0);
        chk("R9 write keeps line", 64'(oe46[base % 16]), 64'd1);
    endtask

    task automatic t_write_mask();
        int base;
        base = fcnt;
        hw(3'd4, (32'd1 << 6) | (32'd1 << 18));
        hw(3'd1, 32'h1234_0000);
        hw(3'd0, acc(1, 0, 4095, 4, 0));
        wait_idle();
        chk("R4 frame count", 64'(fcnt - base), 64'd2);
        chk("R4 page frame at limit", flog[base % 16], ef(2'b01, 2'b01, 5'd6, 5'd31, 16'h0FFF));
        chk("R4 write frame", flog[(base + 1) % 16], ef(2'b01, 2'b01, 5'd6, 5'd4, 16'h1234));
    endtask

    task automatic t_raw_page();
        logic [31:0] v;
        int base;
        base = fcnt; rd_resp = 16'h0F0F;
        hw(3'd1, 32'd63 << 16);
        hw(3'd0, acc(0, 0, 13'h1FFF, 2, 1));
        wait_idle();
        chk("R5 single frame", 64'(fcnt - base), 64'd1);
        chk("R5 raw read frame", flog[base % 16], ef(2'b01, 2'b10, 5'd31, 5'd2, 16'h0F0F));
        hr(3'd1, v);
        chk("R5 read data", 64'(v[15:0]), 64'h0F0F);
    endtask

    task automatic range_case(input string tag, input logic [31:0] w);
        logic [31:0] v;
        int base;
        base = fcnt;
        hw(3'd0, w);
        wait_idle();
        repeat (20) @(negedge clk);
        hr(3'd0, v);
        chk({"R6 fail status ", tag}, 64'(v[1:0]), 64'd2);
        chk({"R6 no frame ", tag}, 64'(fcnt - base), 64'd0);
    endtask

    task automatic t_range();
        logic [31:0] v;
        hw(3'd1, 32'd64 << 16);
        range_case("port 64", acc(0, 0, 0, 0, 0));
        hw(3'd1, 32'd1 << 16);
        range_case("page 4096", acc(0, 0, 4096, 0, 0));
        range_case("page 1FFF untagged", acc(0, 0, 13'h1FFF, 0, 0));
        hw(3'd4, 32'd0);
        range_case("empty mask", acc(1, 0, 0, 0, 0));
        hw(3'd2, (32'd32 << 16) | 32'd5);
        range_case("device 32", acc(0, 1, 0, 0, 0));
        hr(3'd1, v);
        chk("R6 data kept", 64'(v[15:0]), 64'h0F0F);
    endtask

    task automatic t_mmd();
        logic [31:0] v;
        int base;
        base = fcnt; rd_resp = 16'h5A5A;
        hw(3'd1, 32'd3 << 16);
        hw(3'd2, (32'd7 << 16) | 32'h8001);
        hw(3'd0, acc(0, 1, 5, 0, 0));
        wait_idle();
        chk("R7 read frame count", 64'(fcnt - base), 64'd2);
        chk("R7 address frame", flog[base % 16], ef(2'b00, 2'b00, 5'd3, 5'd7, 16'h8001));
        chk("R7 mmd read frame", flog[(base + 1) % 16], ef(2'b00, 2'b11, 5'd3, 5'd7, 16'h5A5A));
        hr(3'd1, v);
        chk("R7 mmd read data", 64'(v[15:0]), 64'h5A5A);
        base = fcnt;
        hw(3'd3, 32'd1 << 2);
        hw(3'd1, 32'hCAFE_0000);
        hw(3'd2, (32'd30 << 16) | 32'h0010);
        hw(3'd0, acc(1, 1, 0, 0, 0));
        wait_idle();
        chk("R7 write address frame", flog[base % 16], ef(2'b00, 2'b00, 5'd2, 5'd30, 16'h0010));
        chk("R7 mmd write frame", flog[(base + 1) % 16], ef(2'b00, 2'b01, 5'd2, 5'd30, 16'hCAFE));
    endtask

    task automatic t_ta_fail();
        logic [31:0] v;
        phy_present = 1'b0;
        hw(3'd1, 32'd4 << 16);
        hw(3'd0, acc(0, 0, 0, 1, 0));
        wait_idle();
        hr(3'd0, v);
        chk("R8 fail on silent phy", 64'(v[1:0]), 64'd2);
        hr(3'd1, v);
        chk("R8 data unchanged", 64'(v[15:0]), 64'h5A5A);
        phy_present = 1'b1; rd_resp = 16'h1111;
        hw(3'd0, acc(0, 0, 0, 1, 0));
        repeat (10) @(negedge clk);
        hr(3'd0, v);
        chk("R8 fail cleared at start", 64'(v[1:0]), 64'd1);
        wait_idle();
        hr(3'd1, v);
        chk("R8 data after retry", 64'(v[15:0]), 64'h1111);
    endtask

    task automatic t_busy_writes();
        logic [31:0] v, w;
        int base;
        base = fcnt; rd_resp = 16'h2222;
        w = acc(0, 0, 2, 3, 0);
        hw(3'd1, 32'd5 << 16);
        hw(3'd0, w);
        repeat (20) @(negedge clk);
        hw(3'd1, 32'hFFFF_0000);
        hw(3'd2, 32'h0);
        hw(3'd3, 32'h0);
        hw(3'd0, 32'h9);
        wait_idle();
        repeat (300) @(negedge clk);
        chk("R10 no extra frame", 64'(fcnt - base), 64'd2);
        chk("R10 read frame", flog[(base + 1) % 16], ef(2'b01, 2'b10, 5'd5, 5'd3, 16'h2222));
        hr(3'd1, v);
        chk("R10 data kept", 64'(v), 64'h0005_2222);
        hr(3'd2, v);
        chk("R10 mmd kept", 64'(v), 64'h001E_0010);
        hr(3'd3, v);
        chk("R10 mask kept", 64'(v), 64'h4);
        hr(3'd0, v);
        chk("R10 access kept", 64'(v), 64'(w & ~32'h1));
    endtask

    task automatic t_low_half();
        logic [31:0] v;
        hw(3'd1, 32'h0001_5555);
        hr(3'd1, v);
        chk("R11 low half read only", 64'(v), 64'h0001_2222);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_paged_read();
        t_write_mask();
        t_raw_page();
        t_range();
        t_mmd();
        t_ta_fail();
        t_busy_writes();
        t_low_half();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule